// File: doc/BRIEF.md
# Passive LCD frame sequencer

The sequencer drives a passive LCD panel from a linear frame buffer held in system memory. Software programs the pixel depth, the split-panel mode, the panel width and height in pixels, the byte range of the frame buffer and a DF rate. The block turns width and height into a count of 4-bit data beats per line and a count of lines per frame. It then walks the buffer with 32-bit word reads and shifts each word out to the panel one nibble at a time. Along with the data it produces a line strobe, a frame strobe and the alternating-drive (DF) level.

A freeze request lets the frame in progress run to its end and then halts the sequencer. Clearing the freeze while enable is still set starts a new frame from the start of the buffer. The busy output gives software a point to poll, so it does not have to wait a fixed delay. The memory side is a plain read port with a valid/ready handshake. Every counter holds its value while a read is not accepted.

Top module: `lcd_frame_seq`

## Requirements
- R1: After reset, busy, rd_valid, lcd_shift, lcd_line, lcd_frame, lcd_df and lcd_data are all 0.
- R2: The number of nibble beats per line is (width/8)*3 when the depth code is 3 (8-bit colour) and split is clear. Otherwise it is width/4. The depth codes are 0 = 1 bit, 1 = 2 bits, 2 = 4 bits and 3 = 8 bits per pixel.
- R3: The number of lines per frame is height, or height/2 when split is set.
- R4: Words are read at byte addresses that start at the base and step by 4. When the next address would be at or beyond the end address, the read address goes back to the base. Every new frame starts again at the base, and any partly used word is dropped.
- R5: Each 32-bit word is shifted out least significant nibble first. A word is taken only in a cycle where rd_valid and rd_ready are both high. rd_addr and the beat counters hold while rd_ready is low.
- R6: lcd_line is high for exactly the one cycle that follows the lcd_shift beat carrying the last nibble of a line.
- R7: lcd_frame is high together with every lcd_shift beat of the first line of a frame, and low at all other times.
- R8: lcd_df starts at 0 and toggles at the end of every (rate+1)-th frame after a start. A rate of 0 toggles it every frame.
- R9: While freeze is set, the current frame completes, and busy falls in the same cycle as the last beat of that frame. After that there are no beats and no reads. Clearing freeze with enable still set starts a new frame at the base address.
- R10: When invert is set, lcd_data is the bitwise complement of the buffer nibble.
- R11: When display-on is clear, lcd_data, lcd_shift, lcd_line, lcd_frame and lcd_df are held at 0, while reads and counting carry on.
- R12: busy rises one cycle after enable is seen with freeze clear. It falls at the freeze point, or one cycle after enable goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Run request |
| cfg_freeze | input | 1 | Stop at the end of the current frame |
| cfg_disp_on | input | 1 | Panel output gate |
| cfg_invert | input | 1 | Complement the panel data |
| cfg_depth | input | 2 | Pixel depth code (bits per pixel = 1 << code) |
| cfg_split | input | 1 | Split-panel mode |
| cfg_width | input | DIM_W | Panel width in pixels |
| cfg_height | input | DIM_W | Panel height in pixels |
| cfg_base | input | ADDR_W | Buffer start byte address (word aligned) |
| cfg_end | input | ADDR_W | Buffer end byte address (exclusive) |
| cfg_df_rate | input | DF_W | Frames per DF toggle, minus one |
| rd_valid | output | 1 | Read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_ready | input | 1 | Read data is present this cycle |
| rd_data | input | 32 | Read data word |
| lcd_data | output | 4 | Panel data nibble |
| lcd_shift | output | 1 | Nibble-valid strobe |
| lcd_line | output | 1 | Line strobe |
| lcd_frame | output | 1 | First-line marker |
| lcd_df | output | 1 | Alternating-drive level |
| busy | output | 1 | Sequencer running |

## Verification
A reference model in the bench follows every beat. It predicts each nibble from a hashed memory image, and it predicts the line, frame and DF levels. The bench runs directed configurations for all four depth codes, with and without split, so that the 3/8 colour formula is told apart from the width/4 formula. Setting the end address below the frame's data need forces the mid-frame wrap to the base, which is not the same as the per-frame restart. A throttled rd_ready shows the stall apart from the unthrottled stream, and further runs exercise freeze with and without an immediate restart, invert, display-off and seeded random configurations.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    localparam int NIB_W         = 4;
    localparam int WORD_W        = 32;
    localparam int NIBS_PER_WORD = WORD_W / NIB_W;
    localparam int WORD_BYTES    = WORD_W / 8;

    typedef enum logic [1:0] {
        DEPTH_1B = 2'd0,
        DEPTH_2B = 2'd1,
        DEPTH_4B = 2'd2,
        DEPTH_8B = 2'd3
    } depth_e;

    typedef struct packed {
        logic [NIB_W-1:0] data;
        logic             shift;
        logic             line;
        logic             frame;
    } lcd_beat_t;

    // Colour without split drives three subpixel nibbles for every 8 pixels.
    function automatic int line_nibbles_m1(depth_e d, logic split, int width);
        if (d == DEPTH_8B && !split)
            return (width / 8) * 3 - 1;
        return width / 4 - 1;
    endfunction

    function automatic int frame_lines_m1(logic split, int height);
        return (split ? height / 2 : height) - 1;
    endfunction

endpackage

// File: rtl/lfs_timing.sv
module lfs_timing #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  logic [CNT_W-1:0] hmax_in,
    input  logic [CNT_W-1:0] lmax_in,
    output logic             h_last,
    output logic             l_last,
    output logic             l_first
);
    logic [CNT_W-1:0] h_q, l_q, hmax_q, lmax_q;

    assign h_last  = (h_q == hmax_q);
    assign l_last  = (l_q == lmax_q);
    assign l_first = (l_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q    <= '0;
            l_q    <= '0;
            hmax_q <= '0;
            lmax_q <= '0;
        end else if (load) begin
            h_q    <= '0;
            l_q    <= '0;
            hmax_q <= hmax_in;
            lmax_q <= lmax_in;
        end else if (adv) begin
            if (h_last) begin
                h_q <= '0;
                l_q <= l_last ? '0 : l_q + 1'b1;
            end else begin
                h_q <= h_q + 1'b1;
            end
        end
    end

    assert_hcount_bound_R2: assert property (@(posedge clk) disable iff (rst)
        h_q <= hmax_q);
    assert_lcount_bound_R3: assert property (@(posedge clk) disable iff (rst)
        l_q <= lmax_q);

endmodule

// File: rtl/lfs_fetch.sv
module lfs_fetch
    import lfs_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              active,
    input  logic              take,
    input  logic [ADDR_W-1:0] base_in,
    input  logic [ADDR_W-1:0] end_in,
    input  logic              rd_ready,
    input  logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              have_word,
    output logic [NIB_W-1:0]  nibble
);
    localparam int IDX_W = $clog2(NIBS_PER_WORD);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NIBS_PER_WORD - 1);

    logic [ADDR_W-1:0] addr_q, base_q, end_q, addr_nx;
    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;
    logic              full_q;

    assign rd_valid  = active && !full_q;
    assign rd_addr   = addr_q;
    assign have_word = full_q;
    assign addr_nx   = addr_q + ADDR_W'(WORD_BYTES);
    assign nibble    = word_q[idx_q * NIB_W +: NIB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            base_q <= '0;
            end_q  <= '0;
            word_q <= '0;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (load) begin
            addr_q <= base_in;
            base_q <= base_in;
            end_q  <= end_in;
            idx_q  <= '0;
            full_q <= 1'b0;
        end else if (rd_valid && rd_ready) begin
            word_q <= rd_data;
            full_q <= 1'b1;
            idx_q  <= '0;
            addr_q <= (addr_nx >= end_q) ? base_q : addr_nx;
        end else if (take) begin
            idx_q <= idx_q + 1'b1;
            if (idx_q == IDX_LAST)
                full_q <= 1'b0;
        end
    end

    assert_addr_window_R4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_addr >= base_q && rd_addr < end_q));
    assert_stall_holds_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready && !load) |=> $stable(rd_addr));

endmodule

// File: rtl/lfs_drive.sv
module lfs_drive
    import lfs_pkg::*;
#(
    parameter int DF_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             emit,
    input  logic [NIB_W-1:0] nibble,
    input  logic             h_last,
    input  logic             l_first,
    input  logic             frame_end,
    input  logic [DF_W-1:0]  df_rate,
    input  logic             disp_on,
    input  logic             invert,
    output logic [NIB_W-1:0] lcd_data,
    output logic             lcd_shift,
    output logic             lcd_line,
    output logic             lcd_frame,
    output logic             lcd_df
);
    lcd_beat_t        beat_q;
    logic             line2_q, df_q;
    logic [DF_W-1:0]  dfc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            line2_q <= 1'b0;
            df_q    <= 1'b0;
            dfc_q   <= '0;
        end else begin
            if (emit)
                beat_q.data <= nibble;
            beat_q.shift <= emit;
            beat_q.line  <= emit && h_last;
            beat_q.frame <= emit && l_first;
            line2_q      <= beat_q.line;
            if (start) begin
                dfc_q <= '0;
            end else if (frame_end) begin
                if (dfc_q == df_rate) begin
                    df_q  <= ~df_q;
                    dfc_q <= '0;
                end else begin
                    dfc_q <= dfc_q + 1'b1;
                end
            end
        end
    end

    assign lcd_data  = disp_on ? (beat_q.data ^ {NIB_W{invert}}) : '0;
    assign lcd_shift = disp_on && beat_q.shift;
    assign lcd_line  = disp_on && line2_q;
    assign lcd_frame = disp_on && beat_q.frame;
    assign lcd_df    = disp_on && df_q;

    assert_line_delay_R6: assert property (@(posedge clk) disable iff (rst)
        line2_q |-> $past(emit && h_last, 2));
    assert_df_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(df_q));

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lfs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DIM_W  = 12,
    parameter int DF_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_enable,
    input  logic              cfg_freeze,
    input  logic              cfg_disp_on,
    input  logic              cfg_invert,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_split,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic [DF_W-1:0]   cfg_df_rate,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [31:0]       rd_data,
    output logic [3:0]        lcd_data,
    output logic              lcd_shift,
    output logic              lcd_line,
    output logic              lcd_frame,
    output logic              lcd_df,
    output logic              busy
);
    localparam int CNT_W = DIM_W;

    logic             running_q, start, emit, frame_end, load;
    logic             have_word, h_last, l_last, l_first;
    logic [NIB_W-1:0] nibble;
    logic [CNT_W-1:0] hmax_cfg, lmax_cfg;

    always_comb begin
        hmax_cfg = CNT_W'(line_nibbles_m1(depth_e'(cfg_depth), cfg_split, int'(cfg_width)));
        lmax_cfg = CNT_W'(frame_lines_m1(cfg_split, int'(cfg_height)));
    end

    assign start     = cfg_enable && !running_q && !cfg_freeze;
    assign emit      = running_q && have_word;
    assign frame_end = emit && h_last && l_last;
    assign load      = start || frame_end;
    assign busy      = running_q;

    always_ff @(posedge clk) begin
        if (rst)
            running_q <= 1'b0;
        else if (!cfg_enable)
            running_q <= 1'b0;
        else if (start)
            running_q <= 1'b1;
        else if (frame_end && cfg_freeze)
            running_q <= 1'b0;
    end

    lfs_timing #(.CNT_W(CNT_W)) u_timing (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .adv     (emit),
        .hmax_in (hmax_cfg),
        .lmax_in (lmax_cfg),
        .h_last  (h_last),
        .l_last  (l_last),
        .l_first (l_first)
    );

    lfs_fetch #(.ADDR_W(ADDR_W)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .active    (running_q),
        .take      (emit),
        .base_in   (cfg_base),
        .end_in    (cfg_end),
        .rd_ready  (rd_ready),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .rd_addr   (rd_addr),
        .have_word (have_word),
        .nibble    (nibble)
    );

    lfs_drive #(.DF_W(DF_W)) u_drive (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .emit      (emit),
        .nibble    (nibble),
        .h_last    (h_last),
        .l_first   (l_first),
        .frame_end (frame_end),
        .df_rate   (cfg_df_rate),
        .disp_on   (cfg_disp_on),
        .invert    (cfg_invert),
        .lcd_data  (lcd_data),
        .lcd_shift (lcd_shift),
        .lcd_line  (lcd_line),
        .lcd_frame (lcd_frame),
        .lcd_df    (lcd_df)
    );

    assert_freeze_boundary_R9: assert property (@(posedge clk) disable iff (rst)
        ($fell(running_q) && $past(cfg_enable)) |-> $past(frame_end && cfg_freeze));
    assert_restart_base_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(running_q) |-> (rd_addr == $past(cfg_base)));
    assert_enable_drop_R12: assert property (@(posedge clk) disable iff (rst)
        !cfg_enable |=> !busy);

endmodule

// File: tb/lcd_frame_seq_test.sv
module lcd_frame_seq_test;
    localparam int ADDR_W = 32;
    localparam int DIM_W  = 12;
    localparam int DF_W   = 4;
    localparam logic [31:0] BASE = 32'h0000_2000;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst = 1'b1;
    logic cfg_enable = 0, cfg_freeze = 0, cfg_disp_on = 1, cfg_invert = 0, cfg_split = 0;
    logic [1:0] cfg_depth = 0;
    logic [DIM_W-1:0] cfg_width = 0, cfg_height = 0;
    logic [ADDR_W-1:0] cfg_base = 0, cfg_end = 0;
    logic [DF_W-1:0] cfg_df_rate = 0;
    logic rd_ready = 1'b0;
    wire rd_valid;
    wire [ADDR_W-1:0] rd_addr;
    wire [31:0] rd_data;
    wire [3:0] lcd_data;
    wire lcd_shift, lcd_line, lcd_frame, lcd_df, busy;

    function automatic logic [31:0] mem_word(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
    endfunction
    assign rd_data = mem_word(rd_addr);

    lcd_frame_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .DF_W(DF_W)) uut (
        .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_freeze(cfg_freeze),
        .cfg_disp_on(cfg_disp_on), .cfg_invert(cfg_invert), .cfg_depth(cfg_depth),
        .cfg_split(cfg_split), .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_base(cfg_base), .cfg_end(cfg_end), .cfg_df_rate(cfg_df_rate),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .lcd_data(lcd_data), .lcd_shift(lcd_shift), .lcd_line(lcd_line),
        .lcd_frame(lcd_frame), .lcd_df(lcd_df), .busy(busy)
    );

    int n_chk = 0, n_fail = 0;

    task automatic check(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected beats per line (R2) and lines per frame (R3), from the requirements.
    function automatic int exp_beats(int d, bit s, int w);
        return (d == 3 && !s) ? (w / 8) * 3 : w / 4;
    endfunction
    function automatic int exp_lines(bit s, int h);
        return s ? h / 2 : h;
    endfunction

    // Reference model state
    bit mon_on = 0, mon_busy = 0, freeze_req = 0, m_line_pend = 0;
    int m_hn, m_ln, m_h, m_l, m_nib, m_rate, m_dfc, m_frames, ready_pct = 100;
    logic [31:0] m_addr, m_base, m_end, w32;
    logic m_df = 0, m_inv = 0;
    logic [3:0] exp4;
    string tag_s;

    always @(negedge clk) begin
        if (mon_on) begin
            check(lcd_line == m_line_pend, "R2 R6 line strobe", lcd_line, m_line_pend);
            m_line_pend = 0;
            if (lcd_shift) begin
                w32 = mem_word(m_addr);
                exp4 = w32[4*m_nib +: 4] ^ {4{m_inv}};
                tag_s = m_inv ? "R10 inverted data" : (m_nib == 0 ? "R4 word address" : "R5 nibble order");
                check(lcd_data == exp4, tag_s, lcd_data, exp4);
                check(lcd_frame == (m_l == 0), "R3 R7 frame strobe", lcd_frame, (m_l == 0));
                m_nib++;
                if (m_nib == 8) begin
                    m_nib = 0;
                    m_addr = m_addr + 4;
                    if (m_addr >= m_end) m_addr = m_base;
                end
                m_h++;
                if (m_h == m_hn) begin
                    m_h = 0;
                    m_line_pend = 1;
                    m_l++;
                    if (m_l == m_ln) begin
                        m_l = 0;
                        m_nib = 0;
                        m_addr = m_base;
                        m_frames++;
                        m_dfc++;
                        if (m_dfc == m_rate + 1) begin
                            m_df = ~m_df;
                            m_dfc = 0;
                        end
                    end
                end
            end else begin
                check(lcd_frame == 1'b0, "R7 frame low between beats", lcd_frame, 0);
            end
            check(lcd_df == m_df, "R8 DF level", lcd_df, m_df);
            if (busy && !mon_busy) begin
                m_h = 0; m_l = 0; m_nib = 0; m_addr = m_base; m_dfc = 0; m_frames = 0;
            end
            if (!busy && mon_busy && freeze_req)
                check(m_h == 0 && m_l == 0, "R9 stop at frame boundary", m_h, 0);
            mon_busy = busy;
        end
        rd_ready <= ($urandom % 100) < ready_pct;
    end

    task automatic wait_busy(bit lvl);
        for (int i = 0; i < 20000; i++) begin
            @(posedge clk);
            if (mon_busy == lvl) return;
        end
        check(0, "R12 busy wait timeout", mon_busy, lvl);
    endtask

    task automatic wait_frames(int n);
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            if (m_frames >= n) return;
        end
        check(0, "R3 frame wait timeout", m_frames, n);
    endtask

    task automatic run_cfg(int d, bit s, int w, int h, int bytes, int rate,
                           bit inv, int rdy, int frames, bit restart);
        @(negedge clk);
        cfg_depth = 2'(d); cfg_split = s; cfg_width = DIM_W'(w); cfg_height = DIM_W'(h);
        cfg_base = BASE; cfg_end = BASE + 32'(bytes); cfg_df_rate = DF_W'(rate);
        cfg_invert = inv; cfg_freeze = 0; freeze_req = 0;
        m_hn = exp_beats(d, s, w); m_ln = exp_lines(s, h);
        m_base = BASE; m_end = BASE + 32'(bytes); m_rate = rate; m_inv = inv;
        ready_pct = rdy;
        mon_on = 1;
        cfg_enable = 1;
        @(negedge clk);
        check(busy == 1'b1, "R12 busy after enable", busy, 1);
        wait_busy(1);
        wait_frames(frames);
        @(negedge clk);
        cfg_freeze = 1; freeze_req = 1;
        wait_busy(0);
        check(m_frames == frames + 1, "R9 current frame completes", m_frames, frames + 1);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            check(!lcd_shift && !rd_valid && !busy, "R9 frozen quiet",
                  {lcd_shift, rd_valid, busy}, 0);
        end
        if (restart) begin
            @(negedge clk);
            cfg_freeze = 0; freeze_req = 0;
            @(negedge clk);
            check(busy == 1'b1, "R9 restart after freeze clear", busy, 1);
            check(rd_addr == BASE, "R9 restart at base", rd_addr, BASE);
            wait_busy(1);
            wait_frames(1);
        end
        @(negedge clk);
        cfg_enable = 0; cfg_freeze = 0; freeze_req = 0;
        @(negedge clk);
        check(busy == 1'b0, "R12 busy clears on disable", busy, 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(busy == 0, "R1 busy", busy, 0);
        check(rd_valid == 0, "R1 rd_valid", rd_valid, 0);
        check(lcd_shift == 0 && lcd_line == 0 && lcd_frame == 0, "R1 strobes",
              {lcd_shift, lcd_line, lcd_frame}, 0);
        check(lcd_df == 0, "R1 df", lcd_df, 0);
        check(lcd_data == 0, "R1 data", lcd_data, 0);

        // R4 mid-frame wrap: 32 beats per frame, only 2 words in the buffer
        run_cfg(0, 0, 16, 8, 8, 0, 0, 100, 2, 1);
        // R8 rate 2, throttled reads (R5), inverted data (R10)
        run_cfg(1, 0, 16, 4, 16, 2, 1, 60, 4, 0);
        // R2 colour with and without split, R3 halved lines
        run_cfg(3, 0, 16, 4, 64, 0, 0, 100, 2, 1);
        run_cfg(3, 1, 16, 4, 64, 1, 0, 50, 2, 0);
        run_cfg(2, 1, 24, 6, 72, 0, 0, 100, 1, 1);

        for (int i = 0; i < 6; i++) begin
            int d, w, h, bytes;
            bit s;
            d = $urandom % 4;
            s = 1'($urandom % 2);
            w = 8 * (1 + $urandom % 4);
            h = 2 * (1 + $urandom % 4);
            bytes = (w * h * (1 << d)) / 8;
            if ($urandom % 3 == 0) bytes = 4 + 4 * ($urandom % 3);
            run_cfg(d, s, w, h, bytes, $urandom % 3, 1'($urandom % 2),
                    ($urandom % 2) ? 100 : 40 + $urandom % 50,
                    1 + $urandom % 2, 1'($urandom % 2));
        end

        // R11 display off: outputs held low, fetch continues
        begin
            int hs;
            hs = 0;
            mon_on = 0;
            ready_pct = 100;
            @(negedge clk);
            cfg_disp_on = 0; cfg_invert = 1;
            cfg_depth = 0; cfg_split = 0; cfg_width = 64; cfg_height = 16;
            cfg_base = BASE; cfg_end = BASE + 128; cfg_df_rate = 0;
            cfg_enable = 1;
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                check(lcd_data == 0 && !lcd_shift && !lcd_line && !lcd_frame && !lcd_df,
                      "R11 outputs gated", {lcd_data, lcd_shift, lcd_line, lcd_frame, lcd_df}, 0);
                if (rd_valid && rd_ready) hs++;
            end
            check(hs > 0, "R11 fetch continues", hs, 1);
            check(busy == 1'b1, "R11 busy while dark", busy, 1);
            cfg_enable = 0;
            @(negedge clk);
            cfg_disp_on = 1; cfg_invert = 0;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule